// File: doc/BRIEF.md
# Multiplexed Address/Data External Bus Master

This block runs the external memory bus of a small 8-bit controller that keeps program and data in separate address spaces. The bus is multiplexed. The low byte of the 16-bit address and the 8-bit data share one group of pins. The high address byte has pins of its own. Tri-state behaviour on the shared pins is modelled by an output value, an output enable and a separate input.

A local master raises `req_i` for one cycle with these values:
- an address,
- a space select (program or data),
- a direction,
- write data.

The block then runs one fixed bus cycle of six states:
1. Address setup.
2. Address latch enable high.
3. Latch enable low, with the address held.
4. Strobe asserted.
5. Data sampled or held.
6. Strobe released.

Program fetches use the program-store strobe. Data accesses use separate read and write strobes. Read data is returned with a one-cycle done pulse. The block takes no new request until the cycle in progress has finished.

Top module: `mux_bus_master`

## Requirements
- R1: After reset, `psen_no`, `rd_no` and `wr_no` are high, `ale_o`, `ad_oe_o`, `busy_o` and `done_o` are low, and `ad_o` is 0.
- R2: With the block idle, `req_i` high at a clock edge starts a bus cycle. `busy_o` is then high for exactly six cycles (busy cycles 1..6), and the block is idle again in the seventh cycle.
- R3: In busy cycles 1..3, `ad_oe_o` is 1 and `ad_o` carries address bits 7..0. In all six busy cycles, `addr_hi_o` carries address bits 15..8.
- R4: `ale_o` is high in busy cycle 2 only.
- R5: A program-space access (`prog_i`=1) drives `psen_no` low in busy cycles 4 and 5. `rd_no` and `wr_no` stay high throughout.
- R6: `psen_no` stays high for the whole of a data-space access (`prog_i`=0).
- R7: A data read (`prog_i`=0, `wr_i`=0) drives `rd_no` low in busy cycles 4 and 5. `ad_oe_o` is 0 in busy cycles 4..6.
- R8: For any read, `rdata_o` takes the value that `ad_i` carries at the clock edge that ends busy cycle 5. It holds that value until the next read finishes, and a write does not change it.
- R9: A data write (`prog_i`=0, `wr_i`=1) drives `wr_no` low in busy cycles 4 and 5. In busy cycles 4..6, `ad_oe_o` is 1 and `ad_o` carries the write data.
- R10: `done_o` is a single-cycle pulse in busy cycle 6, and it is never high while the block is idle.
- R11: `req_i` raised while a cycle is in progress is ignored. The address, strobes and data of that cycle are unaffected, and no further cycle follows.
- R12: The program space is read-only. A request with `prog_i`=1 and `wr_i`=1 runs a program read.
- R13: At most one of `psen_no`, `rd_no` and `wr_no` is low at any time. None of them is low while `ale_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Start a bus cycle (taken only when idle) |
| addr_i | input | 16 | Request address |
| prog_i | input | 1 | 1 selects program space, 0 selects data space |
| wr_i | input | 1 | 1 for write, 0 for read (ignored for program space) |
| wdata_i | input | 8 | Write data |
| busy_o | output | 1 | Bus cycle in progress |
| done_o | output | 1 | One-cycle pulse at the end of a bus cycle |
| rdata_o | output | 8 | Data captured by the most recent read |
| ad_o | output | 8 | Multiplexed address-low / data pins, output value |
| ad_oe_o | output | 1 | Output enable for the multiplexed pins |
| ad_i | input | 8 | Multiplexed pins, input value |
| addr_hi_o | output | 8 | Dedicated high address pins |
| ale_o | output | 1 | Address latch enable, active high |
| psen_no | output | 1 | Program-store read strobe, active low |
| rd_no | output | 1 | Data read strobe, active low |
| wr_no | output | 1 | Data write strobe, active low |

## Verification
Two events can fall in the same cycle: a new request on `req_i` and a bus cycle still in progress. The bench provokes this by raising `req_i` with a different address, space and direction in busy cycle 3. It then checks that every pin of the running cycle still matches the first request, and that the block is idle one cycle after `done_o`. The shared pins also carry the low address and the data in turn. The bench drives a decoy value on `ad_i` in every cycle except busy cycle 5, so a read that samples one cycle early or late returns the wrong value.

// File: rtl/mbm_pkg.sv
package mbm_pkg;
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_ADDR   = 3'd1,
    ST_ALE_HI = 3'd2,
    ST_ALE_LO = 3'd3,
    ST_STRB   = 3'd4,
    ST_DATA   = 3'd5,
    ST_REL    = 3'd6
  } bus_st_e;
endpackage

// File: rtl/mbm_seq.sv
module mbm_seq
  import mbm_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    req_i,
  output logic    accept_o,
  output bus_st_e state_o
);
  bus_st_e state_q, state_d;

  assign accept_o = req_i && (state_q == ST_IDLE);

  always_comb begin
    case (state_q)
      ST_IDLE:   state_d = accept_o ? ST_ADDR : ST_IDLE;
      ST_ADDR:   state_d = ST_ALE_HI;
      ST_ALE_HI: state_d = ST_ALE_LO;
      ST_ALE_LO: state_d = ST_STRB;
      ST_STRB:   state_d = ST_DATA;
      ST_DATA:   state_d = ST_REL;
      ST_REL:    state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign state_o = state_q;

  assert_start_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && req_i) |=> (state_q == ST_ADDR));
  assert_end_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_REL) |=> (state_q == ST_IDLE));
  assert_no_restart_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_IDLE && state_q != ST_REL) |=> (state_q != ST_IDLE && state_q != ST_ADDR));
endmodule

// File: rtl/mbm_req_latch.sv
module mbm_req_latch #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              prog_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              prog_o,
  output logic              wr_o,
  output logic [DATA_W-1:0] wdata_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_o  <= '0;
      prog_o  <= 1'b0;
      wr_o    <= 1'b0;
      wdata_o <= '0;
    end else if (load_i) begin
      addr_o  <= addr_i;
      prog_o  <= prog_i;
      wr_o    <= wr_i && !prog_i; // program space is read-only
      wdata_o <= wdata_i;
    end
  end

  assert_prog_no_write_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prog_o |-> !wr_o);
endmodule

// File: rtl/mbm_pin_ctrl.sv
module mbm_pin_ctrl
  import mbm_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  bus_st_e           state_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              prog_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] ad_i,
  output logic [DATA_W-1:0] ad_o,
  output logic              ad_oe_o,
  output logic [ADDR_W-DATA_W-1:0] addr_hi_o,
  output logic              ale_o,
  output logic              psen_no,
  output logic              rd_no,
  output logic              wr_no,
  output logic              done_o,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int LO_W = DATA_W;

  logic addr_ph, strb_ph, data_ph;

  assign addr_ph = (state_i == ST_ADDR) || (state_i == ST_ALE_HI) || (state_i == ST_ALE_LO);
  assign strb_ph = (state_i == ST_STRB) || (state_i == ST_DATA);
  assign data_ph = strb_ph || (state_i == ST_REL);

  always_comb begin
    ad_oe_o = 1'b0;
    ad_o    = '0;
    if (addr_ph) begin
      ad_oe_o = 1'b1;
      ad_o    = addr_i[LO_W-1:0];
    end else if (data_ph && wr_i) begin
      ad_oe_o = 1'b1;
      ad_o    = wdata_i;
    end
  end

  assign addr_hi_o = addr_i[ADDR_W-1:LO_W];
  assign ale_o     = (state_i == ST_ALE_HI);
  assign psen_no   = !(strb_ph && prog_i);
  assign rd_no     = !(strb_ph && !prog_i && !wr_i);
  assign wr_no     = !(strb_ph && !prog_i && wr_i);
  assign done_o    = (state_i == ST_REL);

  // capture on the edge that ends the last strobe-low cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          rdata_o <= '0;
    else if (state_i == ST_DATA && !wr_i) rdata_o <= ad_i;
  end

  assert_one_strobe_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({!psen_no, !rd_no, !wr_no}) <= 1);
  assert_ale_no_strobe_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ale_o |-> (psen_no && rd_no && wr_no));
  assert_psen_data_space_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_no || !wr_no) |-> psen_no);
  assert_read_released_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_no || !psen_no) |-> !ad_oe_o);
  assert_write_driven_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_no |-> (ad_oe_o && ad_o == wdata_i));
  assert_rdata_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i != ST_DATA) |=> $stable(rdata_o));
endmodule

// File: rtl/mux_bus_master.sv
module mux_bus_master
  import mbm_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              prog_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic [DATA_W-1:0] ad_o,
  output logic              ad_oe_o,
  input  logic [DATA_W-1:0] ad_i,
  output logic [ADDR_W-DATA_W-1:0] addr_hi_o,
  output logic              ale_o,
  output logic              psen_no,
  output logic              rd_no,
  output logic              wr_no
);
  bus_st_e           state;
  logic              accept;
  logic [ADDR_W-1:0] lat_addr;
  logic              lat_prog, lat_wr;
  logic [DATA_W-1:0] lat_wdata;

  mbm_seq u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (req_i),
    .accept_o(accept),
    .state_o (state)
  );

  mbm_req_latch #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_latch (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (accept),
    .addr_i (addr_i),
    .prog_i (prog_i),
    .wr_i   (wr_i),
    .wdata_i(wdata_i),
    .addr_o (lat_addr),
    .prog_o (lat_prog),
    .wr_o   (lat_wr),
    .wdata_o(lat_wdata)
  );

  mbm_pin_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pins (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .state_i  (state),
    .addr_i   (lat_addr),
    .prog_i   (lat_prog),
    .wr_i     (lat_wr),
    .wdata_i  (lat_wdata),
    .ad_i     (ad_i),
    .ad_o     (ad_o),
    .ad_oe_o  (ad_oe_o),
    .addr_hi_o(addr_hi_o),
    .ale_o    (ale_o),
    .psen_no  (psen_no),
    .rd_no    (rd_no),
    .wr_no    (wr_no),
    .done_o   (done_o),
    .rdata_o  (rdata_o)
  );

  assign busy_o = (state != ST_IDLE);

  assert_done_busy_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> busy_o);
  assert_done_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o && !busy_o);
  assert_ale_drives_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ale_o |-> ad_oe_o);
  assert_addr_stable_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !done_o) |=> $stable(addr_hi_o));
  assert_idle_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (psen_no && rd_no && wr_no && !ale_o && !ad_oe_o));
endmodule

// File: tb/mux_bus_master_bench.sv
module mux_bus_master_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req = 1'b0;
  logic [15:0] addr = '0;
  logic       prog = 1'b0;
  logic       wr = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] ad_in = '0;
  logic       busy, done, ad_oe, ale, psen_n, rd_n, wr_n;
  logic [7:0] rdata, ad_out, addr_hi;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  logic [7:0] last_rd = 8'h00;

  always #2 clk = ~clk; // 250 MHz

  mux_bus_master u_mux_bus_master (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .addr_i(addr), .prog_i(prog),
    .wr_i(wr), .wdata_i(wdata), .busy_o(busy), .done_o(done), .rdata_o(rdata),
    .ad_o(ad_out), .ad_oe_o(ad_oe), .ad_i(ad_in), .addr_hi_o(addr_hi),
    .ale_o(ale), .psen_no(psen_n), .rd_no(rd_n), .wr_no(wr_n)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h (t=%0t)", tag, act, exp, $time);
    end
  endtask

  task automatic idle_check(input string tag);
    chk({tag, " busy"}, busy, 0);
    chk({tag, " done"}, done, 0);
    chk({tag, " strobes"}, {psen_n, rd_n, wr_n}, 3'b111);
    chk({tag, " ale"}, ale, 0);
    chk({tag, " ad_oe"}, ad_oe, 0);
  endtask

  // called at a negedge with the block idle
  task automatic run_op(input logic [15:0] a, input logic p, input logic w,
                        input logic [7:0] wd, input logic [7:0] rin, input bit collide);
    logic weff = w && !p;
    logic s;
    idle_check("R10 idle before");
    addr = a; prog = p; wr = w; wdata = wd; req = 1'b1;
    ad_in = ~rin;
    for (int k = 1; k <= 6; k++) begin
      @(negedge clk);
      req = 1'b0;
      if (collide && k == 3) begin // R11: request during cycle
        req = 1'b1; addr = ~a; prog = ~p; wr = ~w; wdata = ~wd;
      end
      ad_in = (k == 5) ? rin : ~rin;
      s = (k == 4 || k == 5);
      chk("R2 busy", busy, 1);
      chk("R10 done", done, (k == 6));
      chk("R3 addr_hi", addr_hi, a[15:8]);
      chk("R4 ale", ale, (k == 2));
      if (k <= 3) begin
        chk("R3 ad_oe", ad_oe, 1);
        chk("R3 ad lo", ad_out, a[7:0]);
      end else if (weff) begin
        chk("R9 ad_oe", ad_oe, 1);
        chk("R9 ad data", ad_out, wd);
      end else begin
        chk("R7 ad_oe", ad_oe, 0);
      end
      chk(p ? "R5 R12 psen" : "R6 psen", psen_n, !(s && p));
      chk(p ? "R5 R12 rd" : "R7 rd", rd_n, !(s && !p && !weff));
      chk(p ? "R5 R12 wr" : "R9 wr", wr_n, !(s && weff));
      if (k == 6) begin
        if (!weff) last_rd = rin;
        chk("R8 rdata", rdata, last_rd);
      end
    end
    req = 1'b0;
    @(negedge clk);
    idle_check("R2 R11 idle after");
    chk("R8 rdata hold", rdata, last_rd);
  endtask

  initial begin
    while (cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    errors++;
    $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    idle_check("R1 reset");
    chk("R1 ad_o", ad_out, 0);
    chk("R1 rdata", rdata, 0);
    rst_n = 1'b1;
    @(negedge clk);
    idle_check("R1 after release");
    // R11: request raised at the first idle cycle only starts one cycle
    for (int i = 0; i < 256; i++) begin
      logic [15:0] a  = 16'(i * 257 + 16'h1357) ^ 16'(i << 9);
      logic [7:0]  wd = 8'(i * 37 + 5);
      logic [7:0]  ri = 8'(i * 91 + 3);
      logic [1:0]  m  = 2'(i);
      // m: 0 program read, 1 data read, 2 data write, 3 program with write flag (R12)
      run_op(a, (m == 0 || m == 3), (m >= 2), wd, ri, (i % 3 == 0));
    end
    // boundary addresses
    run_op(16'h0000, 1'b0, 1'b0, 8'hFF, 8'h00, 1'b0);
    run_op(16'hFFFF, 1'b0, 1'b1, 8'h00, 8'hFF, 1'b1);
    run_op(16'hFF00, 1'b1, 1'b0, 8'hAA, 8'h55, 1'b1);
    run_op(16'h00FF, 1'b1, 1'b1, 8'h55, 8'hAA, 1'b0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule